// File: doc/BRIEF.md
# Slice-Rotating Read Stream Buffer

This block puts a prefetching read buffer in front of a word-wide memory. The memory is split into eight interleaved slices. Bits [4:2] of a byte address pick the slice, so consecutive words sit in consecutive slices. A slice pointer steps to the next slice on every clock. The memory serves at most one request per cycle, and only a request whose word lies in the slice the pointer holds at that moment.

A client opens a stream by pulsing a start strobe with a byte address. The start does not block the client. The fill engine then fetches consecutive words from the first one whose slice comes round. It fills the buffer completely, with 19 words. After that it tops the buffer up in bursts of 6 words each time at least 6 entries are free. The client pops whole words or single bytes, and bytes come out least significant first.

The same client can also make single random reads or writes through the shared port. A random access waits for its own slice. Fill fetches always win the port, so a random access that lands inside a fill burst is pushed to a later turn of its slice.

States of the fill engine:
- `F_IDLE`: no stream is open.
- `F_FETCH`: fetching; a burst is in progress or is waiting for its slice.
- `F_FULL`: every free entry has been claimed.

Transitions of the fill engine:
- Any start moves it to `F_FETCH`.
- `F_FETCH` moves to `F_FULL` after the last fetch of a burst is issued.
- `F_FULL` moves to `F_FETCH` once 6 entries are free.

States of the random-access engine:
- `R_IDLE`
- `R_WAIT`: waiting for the slice and for a cycle the fill engine leaves free.
- `R_DONE`: a single cycle in which the result is presented.

Transitions of the random-access engine:
- `R_IDLE` to `R_WAIT` on an accepted request.
- `R_WAIT` to `R_DONE` on the grant.
- `R_DONE` back to `R_IDLE`.

Top module: `slice_stream_buf`

## Requirements
- R1: The slice pointer is 0 in the first cycle after reset and increases by one, modulo 8, every cycle. Cycle n therefore serves slice n mod 8. A random access asserted for one cycle in cycle c to a word in slice s completes with `rnd_done` high in cycle c + 2 + ((s - c - 1) mod 8) when no fill is active. That is 2 cycles when s = c+1 and 9 cycles when s = c.
- R2: A random write stores the 32-bit word at byte address bits [ADDR_W-1:2], and address bits [1:0] are ignored. A later random read of that word returns the same value on `rnd_rdata` in its `rnd_done` cycle. A request made while `rnd_busy` is high is ignored.
- R3: A fill fetch has priority over a waiting random access. The random access is granted in the first cycle that matches its slice and carries no fill fetch, and it completes one cycle after that grant.
- R4: The stream pops consecutive words, starting at the start word and rising by one word per pop.
- R5: The buffer holds at most 19 words. After the first fill, the next burst starts only when at least 6 entries are free, and that burst fetches 6 consecutive words. With 5 free entries, no fetch occurs.
- R6: A byte pop (`pop_word` = 0) hands out byte 0 (bits 7:0) first, then bytes 1, 2 and 3 of the head word. The fourth byte pop removes the word. A word pop removes the head word whole.
- R7: A new start discards all buffered words and any fetch still in flight from the old stream. `pop_valid` is low in the cycle after the start.
- R8: `pop_valid` is low while the buffer is empty, and a pop requested while it is low has no effect.
- R9: After reset, `pop_valid`, `rnd_busy` and `rnd_done` are low.
- R10: Suppose a start is given in cycle m with a start word in slice s, and no pop takes place. The first fetch is issued in cycle m+1+((s-m-1) mod 8), and `pop_valid` rises two cycles after that fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strm_start | input | 1 | One-cycle pulse that opens a new stream |
| strm_addr | input | ADDR_W | Byte address of the first stream word |
| pop_req | input | 1 | Pop request |
| pop_word | input | 1 | 1: pop a whole word, 0: pop one byte |
| pop_valid | output | 1 | Buffer holds at least one word |
| pop_wdata | output | 32 | Head word |
| pop_bdata | output | 8 | Current byte of the head word |
| rnd_req | input | 1 | One-cycle random access request |
| rnd_we | input | 1 | 1: write, 0: read |
| rnd_addr | input | ADDR_W | Byte address of the random access |
| rnd_wdata | input | 32 | Write data |
| rnd_busy | output | 1 | A random access is in progress |
| rnd_done | output | 1 | Random access finished; read data is valid |
| rnd_rdata | output | 32 | Read data of the random access |

## Verification
- **Latency sweep.** Random accesses are issued with varied idle gaps over 64 words, which covers every slice distance. The measured latency is compared with the modular formula, so the +1 best case and the 0 worst case can be told apart from an off-by-one in the pointer or the grant.
- **Collision probes.** A random access is placed inside the initial burst and again at the head of a top-up. This shows whether fill priority holds and whether the top-up starts at exactly 6 free entries and not at 5.
- **Stream patterns.** Word pops, byte pops, pops into an empty buffer and a restart during a fill check ordering, byte lanes and flushing against arithmetically generated memory contents.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
    typedef enum logic [1:0] {
        F_IDLE,
        F_FETCH,
        F_FULL
    } fill_state_e;

    typedef enum logic [1:0] {
        R_IDLE,
        R_WAIT,
        R_DONE
    } rnd_state_e;
endpackage

// File: rtl/ssb_slice_mem.sv
module ssb_slice_mem #(
    parameter int SLICES = 8,
    parameter int IDX_W  = 10,
    parameter int DW     = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      fill_en,
    input  logic [IDX_W-1:0]          fill_idx,
    input  logic                      rnd_en,
    input  logic                      rnd_we,
    input  logic [IDX_W-1:0]          rnd_idx,
    input  logic [DW-1:0]             rnd_wdata,
    output logic [$clog2(SLICES)-1:0] cur_slice,
    output logic [DW-1:0]             rdata
);
    localparam int SL_W  = $clog2(SLICES);
    localparam int WORDS = 1 << IDX_W;

    logic [DW-1:0] store [WORDS];

    // slice pointer: one step per clock, wraps at SLICES (power of two)
    always_ff @(posedge clk) begin
        if (rst) cur_slice <= '0;
        else     cur_slice <= cur_slice + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rnd_en && rnd_we) store[rnd_idx] <= rnd_wdata;
        if (fill_en)          rdata <= store[fill_idx];
        else if (rnd_en)      rdata <= store[rnd_idx];
    end

    // R1
    fill_align_chk: assert property (@(posedge clk) disable iff (rst)
        fill_en |-> (fill_idx[SL_W-1:0] == cur_slice));
    // R1
    rnd_align_chk: assert property (@(posedge clk) disable iff (rst)
        rnd_en |-> (rnd_idx[SL_W-1:0] == cur_slice));
    // R3
    no_collision_chk: assert property (@(posedge clk) disable iff (rst)
        !(fill_en && rnd_en));
endmodule

// File: rtl/ssb_fill_ctrl.sv
module ssb_fill_ctrl
    import ssb_pkg::*;
#(
    parameter int DEPTH  = 19,
    parameter int CHUNK  = 6,
    parameter int SLICES = 8,
    parameter int IDX_W  = 10,
    parameter int DW     = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [IDX_W-1:0]          start_idx,
    input  logic [$clog2(SLICES)-1:0] cur_slice,
    input  logic [DW-1:0]             rdata,
    input  logic                      pop_req,
    input  logic                      pop_word,
    output logic                      fill_en,
    output logic [IDX_W-1:0]          fill_idx,
    output logic                      pop_valid,
    output logic [DW-1:0]             pop_wdata,
    output logic [7:0]                pop_bdata
);
    localparam int SL_W = $clog2(SLICES);
    localparam int CW   = $clog2(DEPTH + 1);
    localparam int PW   = $clog2(DEPTH);

    fill_state_e    state, nxt;
    logic [IDX_W-1:0] next_idx;
    logic [CW-1:0]  left;
    logic           gen, rv, rv_tag;
    logic [DW-1:0]  slots [DEPTH];
    logic [PW-1:0]  wp, rp;
    logic [CW-1:0]  count;
    logic [1:0]     bptr;
    logic           inflight, buf_wr, take, consume, topup;
    logic [CW:0]    free;

    always_comb begin
        fill_en  = (state == F_FETCH) && (next_idx[SL_W-1:0] == cur_slice);
        fill_idx = next_idx;
        inflight = rv && (rv_tag == gen);
        free     = (CW+1)'(DEPTH) - (CW+1)'(count) - (CW+1)'(inflight);
        topup    = (state == F_FULL) && (free >= (CW+1)'(CHUNK));
        buf_wr   = inflight && !start;
        take     = pop_req && (count != '0) && !start;
        consume  = take && (pop_word || (bptr == 2'd3));
    end

    always_comb begin
        nxt = state;
        unique case (state)
            F_IDLE:  nxt = F_IDLE;
            F_FETCH: if (fill_en && left == CW'(1)) nxt = F_FULL;
            F_FULL:  if (topup) nxt = F_FETCH;
            default: nxt = F_IDLE;
        endcase
        if (start) nxt = F_FETCH;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= F_IDLE;
        else     state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            next_idx <= '0;
            left     <= '0;
            gen      <= 1'b0;
            rv       <= 1'b0;
            rv_tag   <= 1'b0;
            wp       <= '0;
            rp       <= '0;
            count    <= '0;
            bptr     <= '0;
        end else begin
            rv     <= fill_en;
            rv_tag <= gen;
            if (start) begin
                next_idx <= start_idx;
                left     <= CW'(DEPTH);
                gen      <= ~gen;
                wp       <= '0;
                rp       <= '0;
                count    <= '0;
                bptr     <= '0;
            end else begin
                if (fill_en) begin
                    next_idx <= next_idx + 1'b1;
                    left     <= left - 1'b1;
                end else if (topup) begin
                    left <= CW'(CHUNK);
                end
                if (buf_wr) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
                if (consume) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
                count <= count + CW'(buf_wr) - CW'(consume);
                if (take) bptr <= pop_word ? 2'd0 : bptr + 2'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (buf_wr) slots[wp] <= rdata;
    end

    always_comb begin
        pop_valid = (count != '0);
        pop_wdata = slots[rp];
        pop_bdata = pop_wdata[{bptr, 3'b000} +: 8];
    end

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (buf_wr && !consume) |-> (count < CW'(DEPTH)));
    // R7
    flush_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> !pop_valid);
endmodule

// File: rtl/ssb_rand_ctrl.sv
module ssb_rand_ctrl
    import ssb_pkg::*;
#(
    parameter int SLICES = 8,
    parameter int IDX_W  = 10,
    parameter int DW     = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req,
    input  logic                      we,
    input  logic [IDX_W-1:0]          idx_in,
    input  logic [DW-1:0]             wdata_in,
    input  logic [$clog2(SLICES)-1:0] cur_slice,
    input  logic                      fill_en,
    output logic                      mem_en,
    output logic                      mem_we,
    output logic [IDX_W-1:0]          mem_idx,
    output logic [DW-1:0]             mem_wdata,
    output logic                      busy,
    output logic                      done
);
    localparam int SL_W = $clog2(SLICES);

    rnd_state_e       state, nxt;
    logic [IDX_W-1:0] idx_q;
    logic             we_q;
    logic [DW-1:0]    wd_q;

    always_comb begin
        mem_en    = (state == R_WAIT) && (idx_q[SL_W-1:0] == cur_slice) && !fill_en;
        mem_we    = we_q;
        mem_idx   = idx_q;
        mem_wdata = wd_q;
        busy      = (state != R_IDLE);
        done      = (state == R_DONE);
    end

    always_comb begin
        nxt = state;
        unique case (state)
            R_IDLE:  if (req) nxt = R_WAIT;
            R_WAIT:  if (mem_en) nxt = R_DONE;
            R_DONE:  nxt = R_IDLE;
            default: nxt = R_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= R_IDLE;
        else     state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            we_q  <= 1'b0;
            wd_q  <= '0;
        end else if (state == R_IDLE && req) begin
            idx_q <= idx_in;
            we_q  <= we;
            wd_q  <= wdata_in;
        end
    end

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == R_WAIT && $past(state == R_WAIT)) |-> $stable(idx_q));
    // R3
    done_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(mem_en));
endmodule

// File: rtl/slice_stream_buf.sv
module slice_stream_buf #(
    parameter int ADDR_W = 12,
    parameter int SLICES = 8,
    parameter int DEPTH  = 19,
    parameter int CHUNK  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strm_start,
    input  logic [ADDR_W-1:0] strm_addr,
    input  logic              pop_req,
    input  logic              pop_word,
    output logic              pop_valid,
    output logic [31:0]       pop_wdata,
    output logic [7:0]        pop_bdata,
    input  logic              rnd_req,
    input  logic              rnd_we,
    input  logic [ADDR_W-1:0] rnd_addr,
    input  logic [31:0]       rnd_wdata,
    output logic              rnd_busy,
    output logic              rnd_done,
    output logic [31:0]       rnd_rdata
);
    localparam int IDX_W = ADDR_W - 2;
    localparam int SL_W  = $clog2(SLICES);
    localparam int DW    = 32;

    logic [SL_W-1:0]  cur_slice;
    logic             fill_en, r_en, r_we;
    logic [IDX_W-1:0] fill_idx, r_idx;
    logic [DW-1:0]    r_wdata, rdata;

    ssb_slice_mem #(.SLICES(SLICES), .IDX_W(IDX_W), .DW(DW)) u_mem (
        .clk(clk), .rst(rst),
        .fill_en(fill_en), .fill_idx(fill_idx),
        .rnd_en(r_en), .rnd_we(r_we), .rnd_idx(r_idx), .rnd_wdata(r_wdata),
        .cur_slice(cur_slice), .rdata(rdata)
    );

    ssb_fill_ctrl #(.DEPTH(DEPTH), .CHUNK(CHUNK), .SLICES(SLICES),
                    .IDX_W(IDX_W), .DW(DW)) u_fill (
        .clk(clk), .rst(rst),
        .start(strm_start), .start_idx(strm_addr[ADDR_W-1:2]),
        .cur_slice(cur_slice), .rdata(rdata),
        .pop_req(pop_req), .pop_word(pop_word),
        .fill_en(fill_en), .fill_idx(fill_idx),
        .pop_valid(pop_valid), .pop_wdata(pop_wdata), .pop_bdata(pop_bdata)
    );

    ssb_rand_ctrl #(.SLICES(SLICES), .IDX_W(IDX_W), .DW(DW)) u_rnd (
        .clk(clk), .rst(rst),
        .req(rnd_req), .we(rnd_we), .idx_in(rnd_addr[ADDR_W-1:2]),
        .wdata_in(rnd_wdata), .cur_slice(cur_slice), .fill_en(fill_en),
        .mem_en(r_en), .mem_we(r_we), .mem_idx(r_idx), .mem_wdata(r_wdata),
        .busy(rnd_busy), .done(rnd_done)
    );

    assign rnd_rdata = rdata;
endmodule

// File: tb/slice_stream_buf_test.sv
`timescale 1ns/1ps
module slice_stream_buf_test;
    localparam int ADDR_W = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic strm_start = 1'b0;
    logic [ADDR_W-1:0] strm_addr = '0;
    logic pop_req = 1'b0, pop_word = 1'b1;
    logic pop_valid;
    logic [31:0] pop_wdata;
    logic [7:0] pop_bdata;
    logic rnd_req = 1'b0, rnd_we = 1'b0;
    logic [ADDR_W-1:0] rnd_addr = '0;
    logic [31:0] rnd_wdata = '0;
    logic rnd_busy, rnd_done;
    logic [31:0] rnd_rdata;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    slice_stream_buf #(.ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst(rst), .strm_start(strm_start), .strm_addr(strm_addr),
        .pop_req(pop_req), .pop_word(pop_word), .pop_valid(pop_valid),
        .pop_wdata(pop_wdata), .pop_bdata(pop_bdata),
        .rnd_req(rnd_req), .rnd_we(rnd_we), .rnd_addr(rnd_addr),
        .rnd_wdata(rnd_wdata), .rnd_busy(rnd_busy), .rnd_done(rnd_done),
        .rnd_rdata(rnd_rdata)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    function automatic logic [31:0] word_of(int i);
        logic [7:0] b;
        b = 8'(i);
        return {b ^ 8'h5A, b, ~b, b + 8'd3};
    endfunction

    function automatic int mod8(int v);
        return ((v % 8) + 8) % 8;
    endfunction

    // first cycle >= from serving slice s outside the fill window [ws, ws+wl)
    function automatic int grant_cycle(int from, int s, int ws, int wl);
        for (int n = from; n < from + 64; n++)
            if (mod8(n) == s && !(wl > 0 && n >= ws && n < ws + wl)) return n;
        return -1;
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // called just after a negedge; returns just after a negedge with engine idle
    task automatic rnd_access(string tag, logic we, int idx, logic [31:0] wd,
                              int ws, int wl, output logic [31:0] rd);
        int n0, lat, exp_lat;
        n0 = cyc;
        rnd_req = 1'b1; rnd_we = we; rnd_addr = ADDR_W'(idx << 2) | ADDR_W'(idx % 4);
        rnd_wdata = wd;
        lat = 0;
        do begin
            @(negedge clk);
            rnd_req = 1'b0;
            lat++;
        end while (!rnd_done && lat < 40);
        exp_lat = grant_cycle(n0 + 1, mod8(idx), ws, wl) + 1 - n0;
        chk(tag, 32'(cyc - n0), 32'(exp_lat));
        rd = rnd_rdata;
        @(negedge clk);
    endtask

    task automatic pop_one(string tag, logic word, logic [31:0] exp);
        int w = 0;
        while (!pop_valid && w < 60) begin @(negedge clk); w++; end
        if (word) chk(tag, pop_wdata, exp);
        else      chk(tag, {24'h0, pop_bdata}, exp);
        pop_req = 1'b1; pop_word = word;
        @(negedge clk);
        pop_req = 1'b0;
    endtask

    // start a stream; checks first-valid timing, optionally pops into the empty buffer
    task automatic start_stream(string tag, int idx, logic empty_pops);
        int m0, d, w;
        m0 = cyc;
        strm_start = 1'b1; strm_addr = ADDR_W'(idx << 2);
        @(negedge clk);
        strm_start = 1'b0;
        chk({tag, " R7 valid low after start"}, 32'(pop_valid), 32'd0);
        if (empty_pops) begin
            pop_req = 1'b1; pop_word = 1'b1;
            @(negedge clk);
            @(negedge clk);
            pop_req = 1'b0;
        end
        d = mod8(idx - m0 - 1);
        w = 0;
        while (!pop_valid && w < 40) begin @(negedge clk); w++; end
        chk({tag, " R10 first valid cycle"}, 32'(cyc - m0), 32'(3 + d));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int i0, m0, nxt_w;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk("R9 pop_valid", 32'(pop_valid), 0);
        chk("R9 rnd_busy", 32'(rnd_busy), 0);
        chk("R9 rnd_done", 32'(rnd_done), 0);
        // R8 pop on empty buffer before any stream
        pop_req = 1'b1; @(negedge clk); pop_req = 1'b0;
        chk("R8 empty stays empty", 32'(pop_valid), 0);

        // R1 latency sweep with writes, varied gaps over all slice distances
        for (int i = 0; i < 64; i++) begin
            repeat (i % 5) @(negedge clk);
            rnd_access("R1 write latency", 1'b1, i, word_of(i), 0, 0, rd);
        end
        // R2 read back with varied gaps
        for (int k = 0; k < 24; k++) begin
            int idx = (k * 11) % 64;
            repeat (k % 7) @(negedge clk);
            rnd_access("R1 read latency", 1'b0, idx, 32'h0, 0, 0, rd);
            chk("R2 read data", rd, word_of(idx));
        end

        // R8 / R10 stream from word 5 with pops into the empty buffer
        m0 = cyc;
        start_stream("s5", 5, 1'b1);
        i0 = m0 + 1 + mod8(5 - m0 - 1);
        // R3 random read issued during the initial burst
        rnd_access("R3 delayed by fill", 1'b0, 33, 32'h0, i0, 19, rd);
        chk("R3 read data", rd, word_of(33));
        repeat (40) @(negedge clk);
        // R4 first pops; R8 empty-cycle pops had no effect
        for (int k = 0; k < 5; k++) pop_one("R4 word order", 1'b1, word_of(5 + k));
        repeat (30) @(negedge clk);
        // R5 five free entries: no fetch, so no interference
        rnd_access("R5 no refill at 5 free", 1'b0, 8 + mod8(24), 32'h0, 0, 0, rd);
        pop_one("R4 word order", 1'b1, word_of(10));
        // R5 six free entries: burst of 6 from word 24 blocks slice of word 24
        rnd_access("R5 refill burst of 6", 1'b0, 8 + mod8(24), 32'h0,
                   grant_cycle(cyc + 1, mod8(24), 0, 0), 6, rd);
        chk("R5 read data", rd, word_of(8 + mod8(24)));
        for (int k = 11; k < 40; k++) pop_one("R5 continuity", 1'b1, word_of(k));
        // R6 byte pops, little-endian
        nxt_w = 40;
        for (int k = 0; k < 8; k++)
            pop_one("R6 byte lane", 1'b0, 32'((word_of(nxt_w + k / 4) >> (8 * (k % 4))) & 32'hFF));
        pop_one("R6 word after bytes", 1'b1, word_of(42));
        pop_one("R6 byte after word", 1'b0, 32'(word_of(43) & 32'hFF));
        pop_one("R6 word after one byte", 1'b1, word_of(43));
        pop_one("R6 next word", 1'b1, word_of(44));

        // R7 restart during a fill: old data and in-flight fetch dropped
        start_stream("s0", 0, 1'b0);
        pop_one("R7 first of old", 1'b1, word_of(0));
        start_stream("s46", 46, 1'b0);
        for (int k = 0; k < 8; k++) pop_one("R7 new stream", 1'b1, word_of(46 + k));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule